// File: doc/BRIEF.md
# Map-Granular Layer Forwarding Buffer

This block connects two layer engines that run back to back on chip. The upstream engine writes its output feature maps one at a time, with the map loop outermost. The downstream engine consumes input maps in the same outer-loop order. Because the two loop orders line up, each map can be passed on as soon as its last word is written. The block never holds a whole layer's output. It keeps at most two maps, in a pair of map-sized banks that alternate roles. The upstream engine fills one bank while the downstream engine drains the other.

On the write side, the producer streams words under a valid/ready handshake. With each word it presents the index of the map being written. The block checks the index given with the word that completes a map against the index the consumer will expect next. A mismatch means the loop orders disagree, and the block raises an error pulse. On the read side, the consumer pulls words in order while a complete map is present. A last-word flag marks the end of each map. A layer-complete pulse follows the final map of each layer.

Top module: `fwd_map_forwarder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, prod_ready is 1 and cons_valid, order_error and layer_done are 0.
- R2: Words read by the consumer come out in exactly the order the producer wrote them. Whole maps are never reordered or dropped.
- R3: cons_valid is 1 only while at least one completely written, not fully read map is held. It rises in the cycle after the word that completes a map is accepted. It stays 1 until that map's last word is read.
- R4: prod_ready is 0 exactly when two complete maps are held unread. A write offered while prod_ready is 0 is ignored: it changes no stored data and does not count toward a map.
- R5: prod_ready returns to 1 in the cycle after the consumer reads the last word of a map.
- R6: The producer must give map indices in the order 0, 1, ..., NUM_MAPS-1, then start again at 0. order_error pulses for one cycle after a map-completing word whose prod_map_idx differs from that expected value. The expected value advances by one on every completed map, whether or not it matched. The map is still stored and forwarded.
- R7: layer_done pulses for one cycle, in the cycle after the last word of every NUM_MAPS-th map is read. The map count then starts again for the next layer.
- R8: cons_last is 1 exactly while cons_valid is 1 and the word on cons_rd_data is word MAP_WORDS-1 of its map.
- R9: cons_rd_en while cons_valid is 0 is ignored: it neither advances the read position nor frees a map.
- R10: If a map completes on the write side in the same cycle as a map finishes on the read side, the number of held maps stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prod_wr_en | input | 1 | Producer offers a word |
| prod_wr_data | input | WORD_W | Producer word |
| prod_map_idx | input | $clog2(NUM_MAPS) | Index of the map the offered word belongs to |
| prod_ready | output | 1 | Word is accepted when high |
| cons_rd_en | input | 1 | Consumer takes the presented word |
| cons_valid | output | 1 | A complete map is available |
| cons_rd_data | output | WORD_W | Current word of the head map |
| cons_last | output | 1 | Current word is the last of its map |
| order_error | output | 1 | One-cycle pulse on a map-order mismatch |
| layer_done | output | 1 | One-cycle pulse after the last map of a layer is read |

## Verification
Suppose the held-map count were wrong. The first sign would be a wrong prod_ready or cons_valid in the very cycle the map completes or is drained. No bank traffic is needed to expose it. A bank pointer that flipped at the wrong time would corrupt the first word of the next map read, which shows up within one map time. An expected-index or map counter that drifted would go unnoticed until the next map boundary. It would then show as a misplaced order_error or layer_done pulse. The cycle-level reference model checks every port on every clock, so each of these faults is caught at its first visible cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Selects one of the two map banks.
  typedef logic bank_t;

  // Number of complete maps held, 0..2.
  typedef logic [1:0] fill_t;

  localparam fill_t FILL_EMPTY = 2'd0;
  localparam fill_t FILL_FULL  = 2'd2;

endpackage

// File: rtl/fwd_bank_store.sv
module fwd_bank_store
  import fwd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAP_WORDS = 8,
  localparam int AW       = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  bank_t             wr_bank,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  bank_t             rd_bank,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [MAP_WORDS];
    logic              bank_we;

    assign bank_we = wr_en && (wr_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        mem[wr_addr] <= wr_data;
      end
    end

    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];

endmodule

// File: rtl/fwd_prod_ctrl.sv
module fwd_prod_ctrl
  import fwd_pkg::*;
#(
  parameter int MAP_WORDS = 8,
  parameter int NUM_MAPS  = 4,
  localparam int AW       = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1,
  localparam int IW       = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [IW-1:0] map_idx,
  output logic [AW-1:0] wr_addr,
  output bank_t         wr_bank,
  output logic          map_done,
  output logic          order_error
);

  localparam logic [AW-1:0] LAST_WORD = AW'(MAP_WORDS - 1);
  localparam logic [IW-1:0] LAST_MAP  = IW'(NUM_MAPS - 1);

  logic [AW-1:0] wptr_q, wptr_nxt;
  bank_t         bank_q, bank_nxt;
  logic [IW-1:0] exp_q, exp_nxt;
  logic          err_q, err_nxt;
  logic          step_en;

  assign map_done = wr_fire && (wptr_q == LAST_WORD);
  assign step_en  = wr_fire;

  always_comb begin
    wptr_nxt = wptr_q + AW'(1);
    bank_nxt = bank_q;
    exp_nxt  = exp_q;
    err_nxt  = 1'b0;
    if (map_done) begin
      wptr_nxt = '0;
      bank_nxt = ~bank_q;
      exp_nxt  = (exp_q == LAST_MAP) ? '0 : exp_q + IW'(1);
      err_nxt  = (map_idx != exp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      bank_q <= 1'b0;
      exp_q  <= '0;
    end else if (step_en) begin
      wptr_q <= wptr_nxt;
      bank_q <= bank_nxt;
      exp_q  <= exp_nxt;
    end
  end

  // Error pulse register runs every cycle so it clears itself.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
    end
  end

  assign wr_addr     = wptr_q;
  assign wr_bank     = bank_q;
  assign order_error = err_q;

endmodule

// File: rtl/fwd_cons_ctrl.sv
module fwd_cons_ctrl
  import fwd_pkg::*;
#(
  parameter int MAP_WORDS = 8,
  parameter int NUM_MAPS  = 4,
  localparam int AW       = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1,
  localparam int IW       = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output bank_t         rd_bank,
  output logic          at_last,
  output logic          map_done,
  output logic          layer_done
);

  localparam logic [AW-1:0] LAST_WORD = AW'(MAP_WORDS - 1);
  localparam logic [IW-1:0] LAST_MAP  = IW'(NUM_MAPS - 1);

  logic [AW-1:0] rptr_q, rptr_nxt;
  bank_t         bank_q, bank_nxt;
  logic [IW-1:0] mcnt_q, mcnt_nxt;
  logic          done_q, done_nxt;

  assign at_last  = (rptr_q == LAST_WORD);
  assign map_done = rd_fire && at_last;

  always_comb begin
    rptr_nxt = rptr_q + AW'(1);
    bank_nxt = bank_q;
    mcnt_nxt = mcnt_q;
    done_nxt = 1'b0;
    if (map_done) begin
      rptr_nxt = '0;
      bank_nxt = ~bank_q;
      if (mcnt_q == LAST_MAP) begin
        mcnt_nxt = '0;
        done_nxt = 1'b1;
      end else begin
        mcnt_nxt = mcnt_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      bank_q <= 1'b0;
      mcnt_q <= '0;
    end else if (rd_fire) begin
      rptr_q <= rptr_nxt;
      bank_q <= bank_nxt;
      mcnt_q <= mcnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_nxt;
    end
  end

  assign rd_addr    = rptr_q;
  assign rd_bank    = bank_q;
  assign layer_done = done_q;

endmodule

// File: rtl/fwd_map_forwarder.sv
module fwd_map_forwarder
  import fwd_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MAP_WORDS = 8,
  parameter int NUM_MAPS  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prod_wr_en,
  input  logic [WORD_W-1:0]           prod_wr_data,
  input  logic [$clog2(NUM_MAPS)-1:0] prod_map_idx,
  output logic                        prod_ready,
  input  logic                        cons_rd_en,
  output logic                        cons_valid,
  output logic [WORD_W-1:0]           cons_rd_data,
  output logic                        cons_last,
  output logic                        order_error,
  output logic                        layer_done
);

  localparam int AW = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;

  fill_t         fill_q, fill_nxt;
  logic          fill_en;
  logic          wr_fire, rd_fire;
  logic          prod_map_done, cons_map_done;
  logic [AW-1:0] wr_addr, rd_addr;
  bank_t         wr_bank, rd_bank;
  logic          rd_at_last;

  assign prod_ready = (fill_q != FILL_FULL);
  assign cons_valid = (fill_q != FILL_EMPTY);
  assign wr_fire    = prod_wr_en && prod_ready;
  assign rd_fire    = cons_rd_en && cons_valid;

  fwd_prod_ctrl #(
    .MAP_WORDS (MAP_WORDS),
    .NUM_MAPS  (NUM_MAPS)
  ) u_prod (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_fire     (wr_fire),
    .map_idx     (prod_map_idx),
    .wr_addr     (wr_addr),
    .wr_bank     (wr_bank),
    .map_done    (prod_map_done),
    .order_error (order_error)
  );

  fwd_cons_ctrl #(
    .MAP_WORDS (MAP_WORDS),
    .NUM_MAPS  (NUM_MAPS)
  ) u_cons (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (rd_fire),
    .rd_addr    (rd_addr),
    .rd_bank    (rd_bank),
    .at_last    (rd_at_last),
    .map_done   (cons_map_done),
    .layer_done (layer_done)
  );

  fwd_bank_store #(
    .WORD_W    (WORD_W),
    .MAP_WORDS (MAP_WORDS)
  ) u_store (
    .clk     (clk),
    .wr_en   (wr_fire),
    .wr_bank (wr_bank),
    .wr_addr (wr_addr),
    .wr_data (prod_wr_data),
    .rd_bank (rd_bank),
    .rd_addr (rd_addr),
    .rd_data (cons_rd_data)
  );

  assign cons_last = cons_valid && rd_at_last;

  // Held-map count moves only when exactly one side finishes a map.
  assign fill_en = prod_map_done ^ cons_map_done;

  always_comb begin
    fill_nxt = fill_q;
    if (prod_map_done) begin
      fill_nxt = fill_q + 2'd1;
    end else if (cons_map_done) begin
      fill_nxt = fill_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= FILL_EMPTY;
    end else if (fill_en) begin
      fill_q <= fill_nxt;
    end
  end

endmodule

// File: rtl/fwd_map_forwarder_chk.sv
module fwd_map_forwarder_chk (
  input logic clk,
  input logic rst_n,
  input logic prod_wr_en,
  input logic prod_ready,
  input logic cons_rd_en,
  input logic cons_valid,
  input logic cons_last,
  input logic order_error,
  input logic layer_done
);

  // R4
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_valid |-> prod_ready);

  // R5
  ready_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_rd_en && cons_valid && cons_last) |=> prod_ready);

  // R3
  valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_valid && !(cons_rd_en && cons_last)) |=> cons_valid);

  // R6
  error_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_error |-> $past(prod_wr_en && prod_ready));

  // R7
  done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |-> $past(cons_rd_en && cons_valid && cons_last));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    layer_done |=> !layer_done);

endmodule

bind fwd_map_forwarder fwd_map_forwarder_chk u_fwd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prod_wr_en  (prod_wr_en),
  .prod_ready  (prod_ready),
  .cons_rd_en  (cons_rd_en),
  .cons_valid  (cons_valid),
  .cons_last   (cons_last),
  .order_error (order_error),
  .layer_done  (layer_done)
);

// File: tb/test_fwd_map_forwarder.sv
module test_fwd_map_forwarder;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int MAP_WORDS  = 8;
  localparam int NUM_MAPS   = 4;
  localparam int IW         = $clog2(NUM_MAPS);

  logic              clk;
  logic              rst_n;
  logic              prod_wr_en;
  logic [WORD_W-1:0] prod_wr_data;
  logic [IW-1:0]     prod_map_idx;
  logic              prod_ready;
  logic              cons_rd_en;
  logic              cons_valid;
  logic [WORD_W-1:0] cons_rd_data;
  logic              cons_last;
  logic              order_error;
  logic              layer_done;

  fwd_map_forwarder #(
    .WORD_W    (WORD_W),
    .MAP_WORDS (MAP_WORDS),
    .NUM_MAPS  (NUM_MAPS)
  ) i_fwd_map_forwarder (
    .clk          (clk),
    .rst_n        (rst_n),
    .prod_wr_en   (prod_wr_en),
    .prod_wr_data (prod_wr_data),
    .prod_map_idx (prod_map_idx),
    .prod_ready   (prod_ready),
    .cons_rd_en   (cons_rd_en),
    .cons_valid   (cons_valid),
    .cons_rd_data (cons_rd_data),
    .cons_last    (cons_last),
    .order_error  (order_error),
    .layer_done   (layer_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state
  int q_held[$];     // words of completed, unread maps, in order
  int fill_words = 0;
  int held_maps  = 0;
  int rd_pos     = 0;
  int exp_idx    = 0;
  int maps_read  = 0;
  int next_word  = 1;
  bit m_err      = 0;
  bit m_done     = 0;

  task automatic chk(input bit ok, input string req, input string scen,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] at %0t: actual=%0d expected=%0d", req, scen, $time, act, exp);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input bit bad_idx, input string scen);
    bit e_ready, e_valid;
    @(negedge clk);
    prod_wr_en   = wr;
    prod_wr_data = WORD_W'(next_word);
    prod_map_idx = bad_idx ? IW'(exp_idx + 1) : IW'(exp_idx);
    cons_rd_en   = rd;
    #1;
    e_ready = (held_maps < 2);
    e_valid = (held_maps > 0);
    chk(prod_ready == e_ready, "R4", scen, int'(prod_ready), int'(e_ready));
    chk(cons_valid == e_valid, "R3", scen, int'(cons_valid), int'(e_valid));
    if (e_valid) begin
      chk(int'(cons_rd_data) == q_held[0], "R2", scen, int'(cons_rd_data), q_held[0]);
      chk(cons_last == (rd_pos == MAP_WORDS - 1), "R8", scen,
          int'(cons_last), int'(rd_pos == MAP_WORDS - 1));
    end else begin
      chk(cons_last == 1'b0, "R8", scen, int'(cons_last), 0);
    end
    chk(order_error == m_err, "R6", scen, int'(order_error), int'(m_err));
    chk(layer_done == m_done, "R7", scen, int'(layer_done), int'(m_done));
    @(posedge clk);
    m_err  = 0;
    m_done = 0;
    if (rd && e_valid) begin
      void'(q_held.pop_front());
      rd_pos++;
      if (rd_pos == MAP_WORDS) begin
        rd_pos = 0;
        held_maps--;
        maps_read++;
        if (maps_read == NUM_MAPS) begin
          maps_read = 0;
          m_done = 1;
        end
      end
    end
    if (wr && e_ready) begin
      q_held.push_back(next_word);
      next_word = (next_word + 37) % 65536;
      fill_words++;
      if (fill_words == MAP_WORDS) begin
        fill_words = 0;
        held_maps++;
        m_err = bad_idx;
        exp_idx = (exp_idx + 1) % NUM_MAPS;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    prod_wr_en = 1'b0;
    prod_wr_data = '0;
    prod_map_idx = '0;
    cons_rd_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs while reset is held
    chk(prod_ready == 1'b1, "R1", "reset", int'(prod_ready), 1);
    chk(cons_valid == 1'b0, "R1", "reset", int'(cons_valid), 0);
    chk(order_error == 1'b0, "R1", "reset", int'(order_error), 0);
    chk(layer_done == 1'b0, "R1", "reset", int'(layer_done), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: one map written, valid only after its last word
    for (int i = 0; i < MAP_WORDS; i++) step(1, 0, 0, "R3 first map");
    // R10: read one map while the next completes in the same cycle
    for (int i = 0; i < MAP_WORDS; i++) step(1, 1, 0, "R10 overlap");
    // R4: fill both banks, extra writes while stalled are dropped
    for (int i = 0; i < 3 * MAP_WORDS; i++) step(1, 0, 0, "R4 stall");
    // R5: drain, ready returns after each map finishes
    for (int i = 0; i < 3 * MAP_WORDS; i++) step(0, 1, 0, "R5 drain");
    // R9: reads while empty must not advance anything
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R9 empty read");
    for (int i = 0; i < MAP_WORDS; i++) step(1, 0, 0, "R9 refill");
    for (int i = 0; i < MAP_WORDS; i++) step(0, 1, 0, "R9 readback");
    // R6: wrong index on a completing word
    for (int i = 0; i < MAP_WORDS; i++) step(1, 0, 1, "R6 bad index");
    for (int i = 0; i < MAP_WORDS; i++) step(1, 1, 0, "R6 good index");
    for (int i = 0; i < 2 * MAP_WORDS; i++) step(0, 1, 0, "R6 drain");
    // R7: mixed traffic across several layers
    for (int i = 0; i < 1500; i++) begin
      step($urandom_range(0, 99) < 60, $urandom_range(0, 99) < 55,
           $urandom_range(0, 99) < 3, "R7 mixed");
    end
    for (int i = 0; i < 3 * MAP_WORDS; i++) step(0, 1, 0, "R7 final drain");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule